// File: doc/BRIEF.md
# NAND page program sequencer

This block is the host-side engine that writes one page into a NAND flash device. On a start request it opens the program operation and sends the column and row address bytes. It waits out the address-to-data setup interval, then streams the page bytes from a valid/ready source. It closes the operation with a confirm opcode, waits out the busy-onset interval, and follows the device's ready line. It then fetches the status byte and reports the outcome with a one-cycle done pulse and a held fail flag.

Three confirm flavours are selected per operation. A normal program closes with 10h, and its result is bit 0 of status. A cache program closes with 15h; its result is bit 1 of status, which gives the outcome of the preceding cache operation. A plane-queue load closes with 11h, and the device holds that plane until a later 10h or 15h programs every queued plane together. A queue load programs nothing, so it never reports a failure. For targets with several dies, the status is fetched with the die-selecting status opcode followed by the row address bytes, so that only one die drives the bus.

The device side uses one bus cycle per clock. Each cycle carries a write strobe qualified by a command-latch or address-latch flag, or else a read strobe.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset, busy, done, fail, every strobe and data_ready are low, and they stay low until start is raised.
- R2: A start taken while idle produces a command write of 80h with cmd_latch high. Five address writes with addr_latch high follow on the next cycles, in this order: column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16.
- R3: At least TADL_CYC cycles with no strobe separate the last address write from the first data write.
- R4: data_ready is high only in the data phase. Exactly PAGE_BYTES data writes occur, one in each cycle where data_ready and data_valid are both high, and each carries data_in unchanged and in order.
- R5: The confirm command follows the last data write. Its value is set by prog_mode: 2'b00 gives 10h, 2'b01 gives 15h, 2'b10 gives 11h, and 2'b11 gives 10h.
- R6: The status command comes on the later of two cycles: confirm cycle + TWB_CYC + 2, or the cycle after the first cycle in which dev_ready is seen high from confirm cycle + TWB_CYC + 1 onward.
- R7: When multi_die is low, the status command is 70h. When it is high, the status command is 78h, followed by three address writes of row bits 7:0, 15:8 and 23:16.
- R8: Exactly one read strobe follows the status command and its address bytes. done is high for the single cycle after the read strobe.
- R9: In the done cycle, fail shows status bit 0 for a normal program and status bit 1 for a cache program. It is 0 for a plane-queue load. fail keeps that value until the next done.
- R10: start and prog_mode have no effect while busy is high. The running operation completes unchanged, and the block is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| prog_mode | input | 2 | 00 normal, 01 cache, 10 plane queue, 11 normal |
| col_addr | input | 8*COL_BYTES | Column address |
| row_addr | input | 8*ROW_BYTES | Row (block and page) address |
| multi_die | input | 1 | Use the die-selecting status fetch |
| data_in | input | 8 | Page byte from the host |
| data_valid | input | 1 | data_in holds a byte |
| data_ready | output | 1 | Sequencer takes a byte when data_valid is high |
| dev_ready | input | 1 | Device ready/busy line, high when ready |
| bus_in | input | 8 | Byte driven by the device during a read strobe |
| cmd_latch | output | 1 | Current write is a command |
| addr_latch | output | 1 | Current write is an address byte |
| wr_strobe | output | 1 | Write cycle on the device bus |
| rd_strobe | output | 1 | Read cycle on the device bus |
| bus_out | output | 8 | Byte driven to the device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last completed operation |

## Verification
The checker watches four things on every clock. It holds the address-to-data gap against a running count, keeps the latch flags and read strobe mutually exclusive, ties every done pulse to the read strobe just before it, and keeps the fail flag from moving outside a done cycle. Only the bench scenarios can show the exact byte order of the address, data and status phases, the confirm byte chosen by each mode, and the cycle where status fetching resumes after a device busy period of random length. They also cover the fail bit selected by each mode and whether a start request arriving in the middle of an operation is ignored.

// File: rtl/nand_seq_pkg.sv
// Shared types and opcodes for the NAND page program sequencer.
// Assumes an 8-bit device bus with one bus cycle per clock.
package nand_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ADDR, S_TADL, S_DATA, S_CONF,
        S_TWB, S_BUSY, S_STCMD, S_STADDR, S_STREAD, S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_CACHE  = 2'b01,
        PM_QUEUE  = 2'b10,
        PM_ALT    = 2'b11
    } prog_mode_t;

    localparam logic [7:0] OP_LOAD      = 8'h80;
    localparam logic [7:0] OP_CONF_PROG = 8'h10;
    localparam logic [7:0] OP_CONF_CACH = 8'h15;
    localparam logic [7:0] OP_CONF_QUE  = 8'h11;
    localparam logic [7:0] OP_STAT      = 8'h70;
    localparam logic [7:0] OP_STAT_DIE  = 8'h78;

endpackage

// File: rtl/nand_seq_timer.sv
// Down-counting wait timer. Loading value N-1 keeps zero low for N-1 cycles,
// so a state that waits for zero lasts N cycles. Assumes load_val fits W bits.
module nand_seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load or count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nand_seq_addr_sel.sv
// Address byte selector. Index 0 is the low column byte. Column bytes come
// first, then row bytes, each low byte first. Assumes sel < COL_BYTES+ROW_BYTES.
module nand_seq_addr_sel #(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    localparam int NBYTES = COL_BYTES + ROW_BYTES,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic [8*COL_BYTES-1:0] col,
    input  logic [8*ROW_BYTES-1:0] row,
    input  logic [SEL_W-1:0]       sel,
    output logic [7:0]             byte_out
);
    logic [7:0] bytes [NBYTES];

    // Spread the column and row words into one byte list.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        if (i < COL_BYTES) begin : g_col
            assign bytes[i] = col[8*i +: 8];
        end else begin : g_row
            assign bytes[i] = row[8*(i-COL_BYTES) +: 8];
        end
    end

    // Pick the indexed byte.
    always_comb begin
        byte_out = bytes[0];
        for (int k = 0; k < NBYTES; k++)
            if (sel == SEL_W'(k)) byte_out = bytes[k];
    end
endmodule

// File: rtl/nand_seq_status_eval.sv
// Turns a captured status byte into a pass/fail result for the mode used.
// Normal programs report bit 0. Cache programs report bit 1, the outcome of
// the earlier cache operation. Queue loads program nothing and always pass.
module nand_seq_status_eval
    import nand_seq_pkg::*;
(
    input  prog_mode_t mode,
    input  logic [7:0] status,
    output logic       fail_bit
);
    // Choose the status bit that carries the result for this mode.
    always_comb begin
        case (mode)
            PM_CACHE: fail_bit = status[1];
            PM_QUEUE: fail_bit = 1'b0;
            default:  fail_bit = status[0];
        endcase
    end
endmodule

// File: rtl/nand_prog_seq.sv
// NAND page program sequencer: opening command, address bytes, setup wait,
// page data, confirm, busy-onset wait, ready wait, status fetch and result.
// Assumes TADL_CYC >= 1 and TWB_CYC >= 1, and that start is taken only while idle.
// Device bus outputs are decoded from the state, so one byte moves per clock.
module nand_prog_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int COL_BYTES  = 2,
    parameter int ROW_BYTES  = 3,
    parameter int TADL_CYC   = 3,
    parameter int TWB_CYC    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             prog_mode,
    input  logic [8*COL_BYTES-1:0] col_addr,
    input  logic [8*ROW_BYTES-1:0] row_addr,
    input  logic                   multi_die,
    input  logic [7:0]             data_in,
    input  logic                   data_valid,
    output logic                   data_ready,
    input  logic                   dev_ready,
    input  logic [7:0]             bus_in,
    output logic                   cmd_latch,
    output logic                   addr_latch,
    output logic                   wr_strobe,
    output logic                   rd_strobe,
    output logic [7:0]             bus_out,
    output logic                   busy,
    output logic                   done,
    output logic                   fail
);
    localparam int ADDR_CYCLES = COL_BYTES + ROW_BYTES;
    localparam int SEL_W       = $clog2(ADDR_CYCLES);
    localparam int CNT_W       = $clog2(PAGE_BYTES + 1);
    localparam int WAIT_MAX    = (TADL_CYC > TWB_CYC) ? TADL_CYC : TWB_CYC;
    localparam int TMR_W       = $clog2(WAIT_MAX + 1);
    localparam logic [SEL_W-1:0] IDX_ADDR_LAST = SEL_W'(ADDR_CYCLES - 1);
    localparam logic [SEL_W-1:0] IDX_ROW_LAST  = SEL_W'(ROW_BYTES - 1);
    localparam logic [SEL_W-1:0] ROW_OFS       = SEL_W'(COL_BYTES);
    localparam logic [CNT_W-1:0] LAST_BYTE     = CNT_W'(PAGE_BYTES - 1);

    seq_state_t             state, state_nx;
    prog_mode_t             mode_q;
    logic [8*COL_BYTES-1:0] col_q;
    logic [8*ROW_BYTES-1:0] row_q;
    logic                   multi_q;
    logic [SEL_W-1:0]       idx;
    logic [CNT_W-1:0]       byte_cnt;
    logic                   fail_q;
    logic                   data_fire;
    logic                   tmr_load, tmr_zero;
    logic [TMR_W-1:0]       tmr_val;
    logic [SEL_W-1:0]       addr_sel;
    logic [7:0]             addr_byte;
    logic                   fail_eval;
    logic [7:0]             conf_op;

    assign data_fire = (state == S_DATA) && data_valid;

    // Next-state decision for the program sequence.
    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE:   if (start) state_nx = S_CMD;
            S_CMD:    state_nx = S_ADDR;
            S_ADDR:   if (idx == IDX_ADDR_LAST) state_nx = S_TADL;
            S_TADL:   if (tmr_zero) state_nx = S_DATA;
            S_DATA:   if (data_fire && byte_cnt == LAST_BYTE) state_nx = S_CONF;
            S_CONF:   state_nx = S_TWB;
            S_TWB:    if (tmr_zero) state_nx = S_BUSY;
            S_BUSY:   if (dev_ready) state_nx = S_STCMD;
            S_STCMD:  state_nx = multi_q ? S_STADDR : S_STREAD;
            S_STADDR: if (idx == IDX_ROW_LAST) state_nx = S_STREAD;
            S_STREAD: state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // State register and operation parameters latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            mode_q  <= PM_NORMAL;
            col_q   <= '0;
            row_q   <= '0;
            multi_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                mode_q  <= prog_mode_t'(prog_mode);
                col_q   <= col_addr;
                row_q   <= row_addr;
                multi_q <= multi_die;
            end
        end
    end

    // Address byte index, advancing through both address phases.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    idx <= '0;
        else if (state == S_ADDR || state == S_STADDR) idx <= idx + 1'b1;
        else                                           idx <= '0;
    end

    // Page byte counter for the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)              byte_cnt <= '0;
        else if (state == S_IDLE) byte_cnt <= '0;
        else if (data_fire)      byte_cnt <= byte_cnt + 1'b1;
    end

    // Result register, written only when the status byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 fail_q <= 1'b0;
        else if (state == S_STREAD) fail_q <= fail_eval;
    end

    // Wait timer load points: after the last address byte and after confirm.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state == S_ADDR && idx == IDX_ADDR_LAST) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TADL_CYC - 1);
        end else if (state == S_CONF) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TWB_CYC - 1);
        end
    end

    nand_seq_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign addr_sel = (state == S_STADDR) ? idx + ROW_OFS : idx;

    nand_seq_addr_sel #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_addr (
        .col      (col_q),
        .row      (row_q),
        .sel      (addr_sel),
        .byte_out (addr_byte)
    );

    nand_seq_status_eval u_eval (
        .mode     (mode_q),
        .status   (bus_in),
        .fail_bit (fail_eval)
    );

    // Confirm opcode chosen by the latched mode.
    always_comb begin
        case (mode_q)
            PM_CACHE: conf_op = OP_CONF_CACH;
            PM_QUEUE: conf_op = OP_CONF_QUE;
            default:  conf_op = OP_CONF_PROG;
        endcase
    end

    // Device bus drive decoded from the state.
    always_comb begin
        cmd_latch  = 1'b0;
        addr_latch = 1'b0;
        bus_out    = 8'h00;
        case (state)
            S_CMD:    begin cmd_latch = 1'b1;  bus_out = OP_LOAD;   end
            S_ADDR:   begin addr_latch = 1'b1; bus_out = addr_byte; end
            S_DATA:   bus_out = data_in;
            S_CONF:   begin cmd_latch = 1'b1;  bus_out = conf_op;   end
            S_STCMD:  begin cmd_latch = 1'b1;
                            bus_out = multi_q ? OP_STAT_DIE : OP_STAT; end
            S_STADDR: begin addr_latch = 1'b1; bus_out = addr_byte; end
            default:  bus_out = 8'h00;
        endcase
    end

    assign wr_strobe  = cmd_latch || addr_latch || data_fire;
    assign rd_strobe  = (state == S_STREAD);
    assign data_ready = (state == S_DATA);
    assign busy       = (state != S_IDLE);
    assign done       = (state == S_DONE);
    assign fail       = fail_q;
endmodule

// File: rtl/nand_prog_seq_chk.sv
// Cycle checker for the program sequencer, attached by bind. It keeps its own
// count of cycles since the last address write to police the setup gap.
module nand_prog_seq_chk #(
    parameter int TADL_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_latch,
    input logic addr_latch,
    input logic wr_strobe,
    input logic rd_strobe,
    input logic data_ready,
    input logic busy,
    input logic done,
    input logic fail
);
    int since_addr;

    // Count cycles since the last address write, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        since_addr <= 0;
        else if (addr_latch && wr_strobe)  since_addr <= 0;
        else if (since_addr < TADL_CYC)    since_addr <= since_addr + 1;
    end

    // R1: reset leaves the block idle and quiet
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !fail && !wr_strobe && !rd_strobe));

    // R3: a data write is never closer than the setup gap to an address write
    a_r3_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !cmd_latch && !addr_latch) |-> (since_addr >= TADL_CYC));

    // R4: the latch flags and the read strobe never overlap
    a_r4_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_latch, addr_latch, rd_strobe, data_ready}) && !(rd_strobe && wr_strobe));

    // R8: the read strobe is followed by exactly one done cycle
    a_r8_read_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (done && !rd_strobe));

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: fail only moves when a result is reported
    a_r9_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail) |-> done);

    // R10: once busy, the block stays busy until it reports done
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind nand_prog_seq nand_prog_seq_chk #(.TADL_CYC(TADL_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_latch  (cmd_latch),
    .addr_latch (addr_latch),
    .wr_strobe  (wr_strobe),
    .rd_strobe  (rd_strobe),
    .data_ready (data_ready),
    .busy       (busy),
    .done       (done),
    .fail       (fail)
);

// File: tb/nand_prog_seq_test.sv
`timescale 1ns/1ps
// Bench for the program sequencer: directed corner cases plus seeded random
// operations, with a simple device model and a bus log checked against
// expected sequences built from the requirements.
module nand_prog_seq_test;
    localparam int PB   = 8;
    localparam int TADL = 3;
    localparam int TWB  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  prog_mode = 2'b00;
    logic [15:0] col_addr = '0;
    logic [23:0] row_addr = '0;
    logic        multi_die = 1'b0;
    logic [7:0]  data_in = '0;
    logic        data_valid = 1'b0;
    logic        data_ready;
    logic        dev_ready = 1'b1;
    logic [7:0]  bus_in = '0;
    logic        cmd_latch, addr_latch, wr_strobe, rd_strobe;
    logic [7:0]  bus_out;
    logic        busy, done, fail;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    nand_prog_seq #(.PAGE_BYTES(PB), .COL_BYTES(2), .ROW_BYTES(3),
                    .TADL_CYC(TADL), .TWB_CYC(TWB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .prog_mode(prog_mode),
        .col_addr(col_addr), .row_addr(row_addr), .multi_die(multi_die),
        .data_in(data_in), .data_valid(data_valid), .data_ready(data_ready),
        .dev_ready(dev_ready), .bus_in(bus_in), .cmd_latch(cmd_latch),
        .addr_latch(addr_latch), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
        .bus_out(bus_out), .busy(busy), .done(done), .fail(fail)
    );

    // Event log: kind 0 command, 1 address, 2 data, 3 read.
    int   ev_kind [64];
    int   ev_val  [64];
    int   ev_cyc  [64];
    int   ev_n;
    int   xk      [64];
    int   xv      [64];
    int   x_n;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int conf_byte(input logic [1:0] m);
        case (m)
            2'b01:   return 'h15;
            2'b10:   return 'h11;
            default: return 'h10;
        endcase
    endfunction

    function automatic bit exp_fail(input logic [1:0] m, input logic [7:0] st);
        case (m)
            2'b01:   return st[1];
            2'b10:   return 1'b0;
            default: return st[0];
        endcase
    endfunction

    function automatic void push_exp(input int k, input int v);
        xk[x_n] = k;
        xv[x_n] = v;
        x_n++;
    endfunction

    task automatic run_txn(input logic [1:0] m, input logic [15:0] col,
                           input logic [23:0] row, input bit md,
                           input logic [7:0] st, input int bcyc, input bit poke);
        logic [7:0] payload [PB];
        int cyc = 0, busy_left = 0, kd = 0;
        int conf_cyc = -1, rise_cyc = -1, done_cyc = -1;
        int last_addr = -1, first_data = -1, stcmd_cyc = -1, read_cyc = -1;
        int exp_st, mism_hdr = 0, mism_dat = 0, mism_st = 0, nread = 0;
        bit fail_at_done = 1'b0;
        for (int i = 0; i < PB; i++) payload[i] = 8'($urandom);
        ev_n = 0;
        x_n = 0;
        @(negedge clk);
        prog_mode = m; col_addr = col; row_addr = row; multi_die = md;
        bus_in = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cyc < 0 && cyc < 400) begin
            // device model and host stream for this cycle
            if (busy_left > 0) begin
                dev_ready = 1'b0;
                busy_left--;
            end else begin
                if (!dev_ready) rise_cyc = cyc;
                dev_ready = 1'b1;
            end
            data_valid = ($urandom % 4) != 0;
            data_in    = (kd < PB) ? payload[kd] : 8'h00;
            start      = poke && conf_cyc >= 0 && cyc == conf_cyc + 2;
            prog_mode  = start ? ~m : m;
            #1;
            if ((wr_strobe || rd_strobe) && ev_n < 64) begin
                ev_kind[ev_n] = cmd_latch ? 0 : addr_latch ? 1 : rd_strobe ? 3 : 2;
                ev_val[ev_n]  = rd_strobe ? int'(bus_in) : int'(bus_out);
                ev_cyc[ev_n]  = cyc;
                if (ev_kind[ev_n] == 2) begin
                    kd++;
                    if (first_data < 0) first_data = cyc;
                end
                if (ev_kind[ev_n] == 1 && kd == 0) last_addr = cyc;
                if (ev_kind[ev_n] == 0 && kd == PB) begin
                    if (conf_cyc < 0) begin
                        conf_cyc  = cyc;
                        busy_left = bcyc;
                    end else if (stcmd_cyc < 0) begin
                        stcmd_cyc = cyc;
                    end
                end
                if (ev_kind[ev_n] == 3) begin
                    read_cyc = cyc;
                    nread++;
                end
                ev_n++;
            end
            if (done) begin
                done_cyc = cyc;
                fail_at_done = fail;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        prog_mode = m;
        data_valid = 1'b0;
        dev_ready = 1'b1;

        // expected bus sequence
        push_exp(0, 'h80);
        push_exp(1, col[7:0]);  push_exp(1, col[15:8]);
        push_exp(1, row[7:0]);  push_exp(1, row[15:8]); push_exp(1, row[23:16]);
        for (int i = 0; i < PB; i++) push_exp(2, payload[i]);
        push_exp(0, conf_byte(m));
        push_exp(0, md ? 'h78 : 'h70);
        if (md) begin
            push_exp(1, row[7:0]); push_exp(1, row[15:8]); push_exp(1, row[23:16]);
        end
        push_exp(3, st);

        check(done_cyc >= 0, "R8 completion seen", done_cyc, 0);
        check(ev_n == x_n, "R4 bus cycle count", ev_n, x_n);
        for (int i = 0; i < x_n && i < ev_n; i++) begin
            if (ev_kind[i] != xk[i] || ev_val[i] != xv[i]) begin
                if (i < 6) mism_hdr++;
                else if (i < 6 + PB) mism_dat++;
                else if (i > 6 + PB) mism_st++;
            end
        end
        check(mism_hdr == 0, "R2 opening command and address order", mism_hdr, 0);
        check(mism_dat == 0, "R4 page bytes in order", mism_dat, 0);
        check(ev_n > 6 + PB && ev_kind[6+PB] == 0 && ev_val[6+PB] == conf_byte(m),
              "R5 confirm opcode", (ev_n > 6 + PB) ? ev_val[6+PB] : -1, conf_byte(m));
        check(mism_st == 0, "R7 status command and die address", mism_st, 0);
        check(first_data - last_addr >= TADL + 1, "R3 address to data gap",
              first_data - last_addr, TADL + 1);
        exp_st = conf_cyc + TWB + 2;
        if (rise_cyc >= 0 && rise_cyc + 1 > exp_st) exp_st = rise_cyc + 1;
        check(stcmd_cyc == exp_st, "R6 status after busy", stcmd_cyc, exp_st);
        check(nread == 1 && done_cyc == read_cyc + 1, "R8 done after single read",
              done_cyc, read_cyc + 1);
        check(fail_at_done == exp_fail(m, st), "R9 fail bit for mode",
              fail_at_done, exp_fail(m, st));
        repeat (3) @(negedge clk);
        check(fail == fail_at_done && !done, "R9 fail held after done", fail, fail_at_done);
        if (poke)
            check(!busy && !wr_strobe, "R10 start ignored while busy", busy, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check(!busy && !done && !fail && !wr_strobe && !rd_strobe && !data_ready,
              "R1 state in reset", {busy, done, fail, wr_strobe, rd_strobe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fail && !wr_strobe && !rd_strobe && !data_ready,
              "R1 idle after reset", {busy, done, fail, wr_strobe, rd_strobe}, 0);

        // directed corners
        run_txn(2'b00, 16'h1234, 24'hABCDEF, 1'b0, 8'h01, 5, 1'b0); // R9 normal fails
        run_txn(2'b00, 16'h0F0E, 24'h010203, 1'b0, 8'h02, 0, 1'b0); // R9 bit1 ignored
        run_txn(2'b01, 16'h5555, 24'h00AA00, 1'b0, 8'h02, 1, 1'b0); // R9 cache fail
        run_txn(2'b01, 16'hAAAA, 24'hFF00FF, 1'b1, 8'h01, 7, 1'b0); // R9 bit0 ignored
        run_txn(2'b10, 16'h0001, 24'h800000, 1'b1, 8'h03, 2, 1'b0); // R5 queue, R7 die
        run_txn(2'b11, 16'hFFFF, 24'hFFFFFF, 1'b0, 8'h01, 3, 1'b0); // R5 alt mode
        run_txn(2'b00, 16'h2468, 24'h13579B, 1'b0, 8'h00, 0, 1'b1); // R10 poke
        run_txn(2'b01, 16'h3C3C, 24'hC3C3C3, 1'b1, 8'h03, 9, 1'b1); // R10 poke long busy

        // seeded random operations
        for (int t = 0; t < 12; t++)
            run_txn(2'($urandom), 16'($urandom), 24'($urandom), 1'($urandom),
                    8'($urandom), int'($urandom % 12), 1'($urandom));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule